// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers interrupt events for a small 8-bit microcontroller core and decides when the core should jump to its interrupt handler. Seven sources feed it. Two of them sit in the core group: an external pin and a timer overflow. Five sit in the peripheral group: a serial (I2C) port, a change on the upper port pins, an A/D timer overflow, an A/D capture and a comparator. Every source owns a sticky flag and an enable bit. The peripheral sources then pass through a shared group enable, and everything passes through one global enable before a request reaches the core.

The core reads and writes the three registers over a small address/data bus. The core answers a request with an acknowledge strobe. The controller then drops the global enable, drops the request and reports the handler vector address 0x0004 for one cycle. A return strobe sets the global enable again. The wake-up output ignores the global enable, so a sleeping core can be woken by a source it does not want to be interrupted by.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset the global enable, group enable, all enables and all flags are 0, every register reads 0x00, and irq_req, wake, ack_taken and vec_addr are 0.
- R2: Address 0 holds bit 7 global enable, bit 6 peripheral group enable, bit 5 timer enable, bit 4 pin enable, bit 1 timer flag and bit 0 pin flag, with bits 3:2 reading 0. Address 1 holds the peripheral flags and address 2 holds the matching enables, at bit 0 I2C, bit 1 port change, bit 2 A/D timer overflow, bit 3 A/D capture and bit 4 comparator, with bits 7:5 reading 0. Address 3 reads 0x00.
- R3: A one-cycle event sets its flag at the next clock edge whatever the state of any enable bit. The flag then stays set until software writes a 0 to it.
- R4: When an event and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R5: irq_req is registered. It goes high on the clock edge after a flag is set, but only when that flag's enable, the group enable (for peripheral sources) and the global enable are all set. With no pending enabled flag it stays low.
- R6: A peripheral source raises neither irq_req nor wake while the group enable is 0. Core-group sources do not depend on the group enable.
- R7: An acknowledge that is sampled while irq_req is high clears the global enable and irq_req at that edge. In the following cycle ack_taken is 1 and vec_addr is 0x0004. At all other times ack_taken is 0 and vec_addr is 0.
- R8: A return strobe sets the global enable at the next edge, unless an acknowledge or a write to address 0 comes in the same cycle.
- R9: A write to address 0 in the same cycle as an acknowledge sets the global enable to the written bit 7, and ack_taken is still reported.
- R10: wake is 1 in the same cycle as any flag whose enable is set (with the group enable too, for peripheral sources), whether or not the global enable is set.
- R11: A flag that is still set when a return strobe restores the global enable raises irq_req again one edge after the global enable comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ev_pin | input | 1 | External pin event pulse |
| ev_tmr | input | 1 | Timer overflow event pulse |
| ev_per | input | 5 | Peripheral event pulses, bit order as in R2 |
| irq_ack | input | 1 | Core acknowledge strobe |
| irq_ret | input | 1 | Core return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up / terminate-write request |
| ack_taken | output | 1 | Acknowledge was accepted last cycle |
| vec_addr | output | 13 | Handler vector address while ack_taken is high |

## Verification
The hardest case to reach is the race between a software write to the global enable and an acknowledge in the same cycle. To get there the bench first raises a real request from a pin event. It then drives the write strobe and the acknowledge on the same falling edge, once writing the enable to 0 and once writing it to 1, and checks both the readback and ack_taken. A second hard case is a flag still pending across a return strobe, which has to raise the request again without any new event. The bench reaches it by acknowledging, leaving the flag set and issuing the return strobe. Around these directed cases, a sweep covers every source against all eight combinations of its own enable, the group enable and the global enable.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    SEL_CORE  = 2'd0,
    SEL_PFLAG = 2'd1,
    SEL_PEN   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // bit positions inside the core register
  localparam int B_GEN     = 7;
  localparam int B_PGEN    = 6;
  localparam int B_TMR_EN  = 5;
  localparam int B_PIN_EN  = 4;
  localparam int B_TMR_FLG = 1;
  localparam int B_PIN_FLG = 0;

  // request gate: global over (core sources or group-gated peripherals)
  function automatic logic gate_tree(input logic gen, input logic pgen,
                                     input logic core_pend, input logic per_pend);
    return gen & (core_pend | (pgen & per_pend));
  endfunction

  // wake path skips the global gate
  function automatic logic wake_tree(input logic pgen, input logic core_pend,
                                     input logic per_pend);
    return core_pend | (pgen & per_pend);
  endfunction

  // next state of the global enable: write, then acknowledge, then return
  function automatic logic gen_next(input logic cur, input logic wr, input logic wd,
                                    input logic ack, input logic ret);
    if (wr)       return wd;
    else if (ack) return 1'b0;
    else if (ret) return 1'b1;
    else          return cur;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         flag_we,
  input  logic [N-1:0] flag_wd,
  input  logic         en_we,
  input  logic [N-1:0] en_wd,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] en_q,
  output logic         pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic f_r;
    logic e_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_r <= 1'b0;
        e_r <= 1'b0;
      end else begin
        // hardware set beats software clear
        f_r <= (flag_we ? flag_wd[i] : f_r) | ev[i];
        if (en_we) e_r <= en_wd[i];
      end
    end
    assign flag_q[i] = f_r;
    assign en_q[i]   = e_r;
  end

  assign pend = |(flag_q & en_q);
endmodule

// File: rtl/irq_enable_tree.sv
module irq_enable_tree
  import irq_tree_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_wr,
  input  logic wd_gen,
  input  logic wd_pgen,
  input  logic irq_ack,
  input  logic irq_ret,
  input  logic core_pend,
  input  logic per_pend,
  output logic gen_q,
  output logic pgen_q,
  output logic gate_raw,
  output logic irq_req,
  output logic wake,
  output logic ack_taken
);
  assign gate_raw = gate_tree(gen_q, pgen_q, core_pend, per_pend);
  assign wake     = wake_tree(pgen_q, core_pend, per_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q     <= 1'b0;
      pgen_q    <= 1'b0;
      irq_req   <= 1'b0;
      ack_taken <= 1'b0;
    end else begin
      gen_q     <= gen_next(gen_q, core_wr, wd_gen, irq_ack, irq_ret);
      if (core_wr) pgen_q <= wd_pgen;
      irq_req   <= gate_raw & ~irq_ack;
      ack_taken <= irq_ack & irq_req;
    end
  end
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int          NPER   = 5,
  parameter int          VW     = 13,
  parameter logic [12:0] VECTOR = 13'h0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ev_pin,
  input  logic            ev_tmr,
  input  logic [NPER-1:0] ev_per,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic            irq_req,
  output logic            wake,
  output logic            ack_taken,
  output logic [VW-1:0]   vec_addr
);
  localparam int NCORE = 2;

  reg_sel_e sel;
  logic core_wr, pflag_wr, pen_wr;
  logic [NCORE-1:0] core_flag, core_en;
  logic [NPER-1:0]  per_flag, per_en;
  logic core_pend, per_pend;
  logic gen_q, pgen_q, gate_raw;

  assign sel      = reg_sel_e'(bus_addr);
  assign core_wr  = bus_wr && (sel == SEL_CORE);
  assign pflag_wr = bus_wr && (sel == SEL_PFLAG);
  assign pen_wr   = bus_wr && (sel == SEL_PEN);

  irq_flag_bank #(.N(NCORE)) u_core_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      ({ev_tmr, ev_pin}),
    .flag_we (core_wr),
    .flag_wd ({bus_wdata[B_TMR_FLG], bus_wdata[B_PIN_FLG]}),
    .en_we   (core_wr),
    .en_wd   ({bus_wdata[B_TMR_EN], bus_wdata[B_PIN_EN]}),
    .flag_q  (core_flag),
    .en_q    (core_en),
    .pend    (core_pend)
  );

  irq_flag_bank #(.N(NPER)) u_per_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_per),
    .flag_we (pflag_wr),
    .flag_wd (bus_wdata[NPER-1:0]),
    .en_we   (pen_wr),
    .en_wd   (bus_wdata[NPER-1:0]),
    .flag_q  (per_flag),
    .en_q    (per_en),
    .pend    (per_pend)
  );

  irq_enable_tree u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_wr   (core_wr),
    .wd_gen    (bus_wdata[B_GEN]),
    .wd_pgen   (bus_wdata[B_PGEN]),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .core_pend (core_pend),
    .per_pend  (per_pend),
    .gen_q     (gen_q),
    .pgen_q    (pgen_q),
    .gate_raw  (gate_raw),
    .irq_req   (irq_req),
    .wake      (wake),
    .ack_taken (ack_taken)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CORE: begin
        bus_rdata[B_GEN]     = gen_q;
        bus_rdata[B_PGEN]    = pgen_q;
        bus_rdata[B_TMR_EN]  = core_en[1];
        bus_rdata[B_PIN_EN]  = core_en[0];
        bus_rdata[B_TMR_FLG] = core_flag[1];
        bus_rdata[B_PIN_FLG] = core_flag[0];
      end
      SEL_PFLAG: bus_rdata[NPER-1:0] = per_flag;
      SEL_PEN:   bus_rdata[NPER-1:0] = per_en;
      default:   bus_rdata = '0;
    endcase
  end

  assign vec_addr = ack_taken ? VECTOR[VW-1:0] : '0;
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_wdata,
  input logic       core_wr,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       ev_pin,
  input logic       irq_req,
  input logic       ack_taken,
  input logic       wake,
  input logic       gen_q,
  input logic [1:0] core_flag,
  input logic [1:0] core_en
);
  assert_req_needs_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gen_q));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !core_wr) |=> !gen_q);

  assert_ack_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken |-> $past(irq_ack));

  assert_ret_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && !core_wr) |=> gen_q);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> (gen_q == $past(bus_wdata[7])));

  assert_pin_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin |=> core_flag[0]);

  assert_wake_no_gen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pin && core_en[0] && !core_wr) |=> wake);
endmodule

bind irq_tree_ctrl irq_tree_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .core_wr   (core_wr),
  .irq_ack   (irq_ack),
  .irq_ret   (irq_ret),
  .ev_pin    (ev_pin),
  .irq_req   (irq_req),
  .ack_taken (ack_taken),
  .wake      (wake),
  .gen_q     (gen_q),
  .core_flag (core_flag),
  .core_en   (core_en)
);

// File: tb/irq_tree_ctrl_test.sv
module irq_tree_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ev_pin = 1'b0, ev_tmr = 1'b0;
  logic [4:0]  ev_per = '0;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;
  logic        irq_req, wake, ack_taken;
  logic [12:0] vec_addr;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_tree_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pin(ev_pin),
    .ev_tmr(ev_tmr), .ev_per(ev_per), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .wake(wake), .ack_taken(ack_taken), .vec_addr(vec_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // src 0 pin, 1 timer, 2..6 peripheral bit src-2
  task automatic pulse(input int src);
    @(negedge clk);
    if (src == 0) ev_pin = 1'b1;
    else if (src == 1) ev_tmr = 1'b1;
    else ev_per[src-2] = 1'b1;
    @(negedge clk);
    ev_pin = 1'b0; ev_tmr = 1'b0; ev_per = '0;
  endtask

  task automatic clear_all();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    @(negedge clk);
  endtask

  task automatic strobe_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 irq_req", irq_req, 0);
    chk("R1 wake", wake, 0);
    chk("R1 ack_taken", ack_taken, 0);
    chk("R1 vec_addr", vec_addr, 0);

    // R2 register map
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 core", d, 8'hF3);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 pflag", d, 8'h1F);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 pen", d, 8'h1F);
    rd(2'd3, d); chk("R2 unused", d, 8'h00);
    clear_all();

    // R3 R5 R6 R10 sweep: every source x own/group/global enable
    for (int s = 0; s < 7; s++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        logic own, pg, g, path;
        logic [7:0] cw;
        own = cfg[0]; pg = cfg[1]; g = cfg[2];
        path = own & ((s < 2) | pg);
        clear_all();
        wr(2'd2, (s >= 2 && own) ? 8'(1 << (s-2)) : 8'h00);
        cw = {g, pg, (s == 1) & own, (s == 0) & own, 4'h0};
        wr(2'd0, cw);
        @(negedge clk);
        chk("R5 idle", irq_req, 0);
        pulse(s);
        if (s < 2) begin rd(2'd0, d); chk("R3 core flag", d[s], 1); end
        else begin rd(2'd1, d); chk("R3 per flag", d, 8'(1 << (s-2))); end
        chk("R6 R10 wake", wake, path);
        @(negedge clk);
        chk("R5 R6 irq_req", irq_req, g & path);
        if (s < 2) begin rd(2'd0, d); chk("R3 still set", d[s], 1); end
      end
    end
    clear_all();

    // R4 set beats clear
    wr(2'd2, 8'h01);
    @(negedge clk);
    bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'h00; ev_per = 5'h01;
    @(negedge clk);
    bus_wr = 1'b0; ev_per = '0;
    rd(2'd1, d); chk("R4 flag kept", d, 8'h01);
    clear_all();

    // R7 acknowledge without request
    strobe_ack();
    chk("R7 no take", ack_taken, 0);
    chk("R7 no vector", vec_addr, 0);

    // R7 R8 R11 service cycle
    wr(2'd0, 8'h90);
    pulse(0);
    @(negedge clk);
    chk("R5 req up", irq_req, 1);
    strobe_ack();
    chk("R7 ack_taken", ack_taken, 1);
    chk("R7 vector", vec_addr, 13'h0004);
    chk("R7 req drop", irq_req, 0);
    rd(2'd0, d); chk("R7 gen clear", d, 8'h11);
    @(negedge clk);
    chk("R7 ack one cycle", ack_taken, 0);
    chk("R7 vector off", vec_addr, 0);
    chk("R10 wake w/o gen", wake, 1);
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    rd(2'd0, d); chk("R8 gen set", d[7], 1);
    @(negedge clk);
    chk("R11 re-request", irq_req, 1);
    wr(2'd0, 8'h90);
    @(negedge clk);
    chk("R3 sw clear", irq_req, 0);

    // R9 write clears gen in same cycle as acknowledge
    pulse(0);
    @(negedge clk);
    chk("R9 req up", irq_req, 1);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h11; irq_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_ack = 1'b0;
    chk("R9 ack_taken", ack_taken, 1);
    rd(2'd0, d); chk("R9 gen written 0", d, 8'h11);
    wr(2'd0, 8'h91);
    @(negedge clk);
    chk("R9 req again", irq_req, 1);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h91; irq_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_ack = 1'b0;
    chk("R9 ack_taken 2", ack_taken, 1);
    rd(2'd0, d); chk("R9 gen written 1", d[7], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule